// File: doc/BRIEF.md
# Multiplexed Parallel Bus Slave

This block sits between a host microcontroller's external-memory bus and the display pipeline of the chip. The host bus carries address and data on one 16-bit set of lines. An active-low address-valid strobe marks the address phase. Chip select, write strobe and read strobe are also active low, and all of them arrive with no relation to the system clock. The block brings every strobe into the system clock domain through two flops and then looks for its release edge. It holds the address seen when address-valid is released. On the release of the write strobe it takes the data word.

Writes to the upper half of the address space carry pixels. The block joins each one with its address into a single wide word and offers it to a downstream buffer FIFO with a one-cycle push. Because address and data travel together, a pixel cannot be separated from its location. Writes to the lower half go to a small register map. One control address there selects the active panel-timing preset. For reads, the map returns the latest touch X and Y coordinates. The data lines are split into input, output and output-enable, so that the pad ring can place the tristate buffer.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset `fifo_push`, `overflow`, `bus_ad_oe` and `panel_sel` are all 0.
- R2: The address is taken from `bus_ad_i` on the release (low-to-high) of `bus_av_n` while chip select is asserted. It stays in force for later data and read phases until the next such release.
- R3: A write whose latched address has bit 15 set produces exactly one `fifo_push` pulse, lasting one cycle, 3 clock edges after the write strobe is released. `fifo_word[31:16]` holds the address and `fifo_word[15:0]` holds the data. `fifo_word` changes only with a push.
- R4: A write whose latched address has bit 15 clear never produces a push.
- R5: A write to address 0x0002 sets `panel_sel` to the data value when that value is below the preset count (3). Larger values leave `panel_sel` unchanged.
- R6: Reads return `touch_x` at address 0x0000, `touch_y` at 0x0001 and `panel_sel` zero-extended at 0x0002. Every other address returns 0.
- R7: `bus_ad_oe` is 1 exactly when `bus_cs_n` and `bus_re_n` are both low.
- R8: A pixel write while `fifo_full` is 1 is dropped with no push, and `overflow` goes to 1. `overflow` stays at 1 until reset, and later writes still push normally.
- R9: Address-valid and write strobe pulses made while `bus_cs_n` is high latch nothing and push nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_av_n | input | 1 | Address-valid strobe, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_re_n | input | 1 | Read strobe, active low |
| bus_ad_i | input | 16 | Multiplexed address/data from pad |
| bus_ad_o | output | 16 | Read data to pad |
| bus_ad_oe | output | 1 | Pad output enable |
| touch_x | input | 16 | Latest touch X coordinate |
| touch_y | input | 16 | Latest touch Y coordinate |
| panel_sel | output | 2 | Active panel-timing preset index |
| fifo_full | input | 1 | Downstream FIFO full |
| fifo_push | output | 1 | One-cycle push strobe |
| fifo_word | output | 32 | Address and data joined for the FIFO |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Suppose the latched address is corrupted. The next pixel word then leaves with the wrong upper half, or lands in the register map with no push. A read then returns the wrong register within about six clocks of the read strobe. A wrong synchroniser or edge state shows up as a push at the wrong cycle count after the write strobe is released, as a double push, or as a missing push. The bench pins the latency to exactly three edges. Problems in the preset register or the overflow state show on `panel_sel` and `overflow` at the next bus transaction.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    // indices into the synchronised strobe vector
    localparam int unsigned STB_CS = 0;
    localparam int unsigned STB_AV = 1;
    localparam int unsigned STB_WE = 2;
    localparam int unsigned STB_COUNT = 3;

    // register map offsets in the low half of the address space
    localparam int unsigned REG_TOUCH_X = 0;
    localparam int unsigned REG_TOUCH_Y = 1;
    localparam int unsigned REG_PANEL   = 2;
endpackage

// File: rtl/mbs_strobe_sync.sv
module mbs_strobe_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] active,
    output logic [WIDTH-1:0] release_pulse
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [WIDTH-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, s3: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign active        = ~st_q.s2;
    assign release_pulse = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned NUM_PANELS = 3,
    localparam int unsigned SEL_W     = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] touch_x,
    input  logic [DATA_W-1:0] touch_y,
    output logic [SEL_W-1:0]  panel_sel,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [SEL_W-1:0]  panel;
        logic [DATA_W-1:0] rd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_W'(REG_PANEL)
                  && 32'(wr_data) < 32'(NUM_PANELS)) begin
            st_d.panel = wr_data[SEL_W-1:0];
        end
        if (addr == ADDR_W'(REG_TOUCH_X)) begin
            st_d.rd = touch_x;
        end else if (addr == ADDR_W'(REG_TOUCH_Y)) begin
            st_d.rd = touch_y;
        end else if (addr == ADDR_W'(REG_PANEL)) begin
            st_d.rd = DATA_W'(st_q.panel);
        end else begin
            st_d.rd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign panel_sel = st_q.panel;
    assign rd_data   = st_q.rd;
endmodule

// File: rtl/mbs_push.sv
module mbs_push #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] word_in,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_word,
    output logic              overflow
);
    typedef struct packed {
        logic              push;
        logic [WORD_W-1:0] word;
        logic              ovf;
    } push_t;

    push_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        if (push_req) begin
            if (fifo_full) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.push = 1'b1;
                st_d.word = word_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_push = st_q.push;
    assign fifo_word = st_q.word;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned NUM_PANELS = 3,
    localparam int unsigned SEL_W     = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1,
    localparam int unsigned WORD_W    = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_av_n,
    input  logic              bus_we_n,
    input  logic              bus_re_n,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] touch_x,
    input  logic [DATA_W-1:0] touch_y,
    output logic [SEL_W-1:0]  panel_sel,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_word,
    output logic              overflow
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } top_t;

    top_t st_d, st_q;

    logic [STB_COUNT-1:0] pins_n;
    logic [STB_COUNT-1:0] stb_act;
    logic [STB_COUNT-1:0] stb_rel;
    logic                 wr_evt;
    logic                 frame_hit;
    logic [DATA_W-1:0]    rd_data;

    always_comb begin
        pins_n         = '1;
        pins_n[STB_CS] = bus_cs_n;
        pins_n[STB_AV] = bus_av_n;
        pins_n[STB_WE] = bus_we_n;
    end

    mbs_strobe_sync #(.WIDTH(STB_COUNT)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_n         (pins_n),
        .active        (stb_act),
        .release_pulse (stb_rel)
    );

    always_comb begin
        st_d = st_q;
        if (stb_rel[STB_AV] && stb_act[STB_CS]) begin
            st_d.addr = bus_ad_i[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_evt    = stb_rel[STB_WE] & stb_act[STB_CS];
    assign frame_hit = st_q.addr[ADDR_W-1];

    mbs_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NUM_PANELS (NUM_PANELS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (st_q.addr),
        .wr_en     (wr_evt & ~frame_hit),
        .wr_data   (bus_ad_i),
        .touch_x   (touch_x),
        .touch_y   (touch_y),
        .panel_sel (panel_sel),
        .rd_data   (rd_data)
    );

    mbs_push #(.WORD_W(WORD_W)) u_push (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_evt & frame_hit),
        .word_in   ({st_q.addr, bus_ad_i}),
        .fifo_full (fifo_full),
        .fifo_push (fifo_push),
        .fifo_word (fifo_word),
        .overflow  (overflow)
    );

    // pad enable follows the raw pins so the host sees data without delay
    assign bus_ad_oe = ~bus_cs_n & ~bus_re_n;
    assign bus_ad_o  = rd_data;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned NUM_PANELS = 3,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned WORD_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_push,
    input logic [WORD_W-1:0] fifo_word,
    input logic              overflow,
    input logic [SEL_W-1:0]  panel_sel
);
    a_r3_push_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);

    a_r3_word_moves_with_push: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_word) |-> fifo_push);

    a_r4_push_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> fifo_word[WORD_W-1]);

    a_r5_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(panel_sel) < 32'(NUM_PANELS));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r8_drop_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !fifo_push);
endmodule

bind mux_bus_slave mbs_checker #(
    .ADDR_W     (ADDR_W),
    .NUM_PANELS (NUM_PANELS),
    .SEL_W      (SEL_W),
    .WORD_W     (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_push (fifo_push),
    .fifo_word (fifo_word),
    .overflow  (overflow),
    .panel_sel (panel_sel)
);

// File: tb/mux_bus_slave_tb_top.sv
module mux_bus_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, av_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [15:0] tx = '0, ty = '0;
    logic [1:0]  psel;
    logic        full = 1'b0;
    logic        push;
    logic [31:0] word;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int push_cnt = 0;
    int last_push_cyc = 0;
    int rel_cyc = 0;
    logic [31:0] last_word = '0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (push) begin
            push_cnt++;
            last_push_cyc = cyc;
            last_word = word;
        end
    end

    mux_bus_slave dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(cs_n), .bus_av_n(av_n), .bus_we_n(we_n), .bus_re_n(re_n),
        .bus_ad_i(ad_i), .bus_ad_o(ad_o), .bus_ad_oe(ad_oe),
        .touch_x(tx), .touch_y(ty), .panel_sel(psel),
        .fifo_full(full), .fifo_push(push), .fifo_word(word), .overflow(ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic addr_phase(input logic [15:0] a, input bit sel);
        @(negedge clk);
        cs_n = !sel;
        ad_i = a;
        av_n = 1'b0;
        repeat (3) @(negedge clk);
        av_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit sel);
        addr_phase(a, sel);
        ad_i = d;
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        rel_cyc = cyc;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        ad_i = 16'hDEAD;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_data(output logic [15:0] d);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R7 oe with cs low re high", 32'(ad_oe), 0);
        re_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 oe with cs low re low", 32'(ad_oe), 1);
        d = ad_o;
        re_n = 1'b1;
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        addr_phase(a, 1'b1);
        ad_i = 16'h0000;
        repeat (2) @(negedge clk);
        read_data(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] rd;
        int exp_sel;
        int base;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 push", 32'(push), 0);
        chk("R1 overflow", 32'(ovf), 0);
        chk("R1 oe", 32'(ad_oe), 0);
        chk("R1 panel_sel", 32'(psel), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 pixel write sweep: word layout and exact latency
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a, d;
            a = 16'h8000 | 16'(i * 16'h0811);
            d = 16'(i * 16'h1357) ^ 16'hA5A5;
            base = push_cnt;
            bus_write(a, d, 1'b1);
            chk("R3 one push per write", 32'(push_cnt - base), 1);
            chk("R3 word {addr,data}", last_word, {a, d});
            chk("R3 latency 3 edges", 32'(last_push_cyc - rel_cyc), 3);
        end

        // R4 register-region writes never push
        for (int i = 0; i < 4; i++) begin
            logic [15:0] a;
            a = (i == 3) ? 16'h7FFF : 16'(i == 2 ? 3 : i);
            base = push_cnt;
            bus_write(a, 16'h0001, 1'b1);
            chk("R4 no push for register write", 32'(push_cnt - base), 0);
            chk("R4 panel_sel untouched", 32'(psel), 0);
        end

        // R5 preset select sweep, including out-of-range values
        exp_sel = 0;
        for (int v = 0; v < 6; v++) begin
            int ord;
            ord = (v * 5 + 1) % 6;
            bus_write(16'h0002, 16'(ord), 1'b1);
            if (ord < 3) exp_sel = ord;
            chk("R5 panel_sel", 32'(psel), 32'(exp_sel));
            bus_read(16'h0002, rd);
            chk("R6 panel readback", 32'(rd), 32'(exp_sel));
        end
        bus_write(16'h0002, 16'h8001, 1'b1);
        chk("R5 large value ignored", 32'(psel), 32'(exp_sel));

        // R6 touch coordinate reads
        for (int i = 0; i < 4; i++) begin
            tx = 16'(16'h0F1E * (i + 1));
            ty = ~16'(16'h0321 * (i + 3));
            bus_read(16'h0000, rd);
            chk("R6 touch_x", 32'(rd), 32'(tx));
            bus_read(16'h0001, rd);
            chk("R6 touch_y", 32'(rd), 32'(ty));
        end
        bus_read(16'h0005, rd);
        chk("R6 unmapped low", 32'(rd), 0);
        bus_read(16'h8000, rd);
        chk("R6 unmapped frame", 32'(rd), 0);

        // R7 oe stays off with cs high and re low
        @(negedge clk);
        re_n = 1'b0;
        @(negedge clk);
        chk("R7 oe with cs high", 32'(ad_oe), 0);
        re_n = 1'b1;

        // R2/R9 unselected address phase keeps the old address
        bus_read(16'h0001, rd);
        addr_phase(16'h0000, 1'b0);
        repeat (2) @(negedge clk);
        read_data(rd);
        chk("R9 address kept when deselected", 32'(rd), 32'(ty));
        chk("R2 address from last selected phase", 32'(rd), 32'(ty));

        // R9 deselected pixel write does nothing
        bus_write(16'h9000, 16'h1111, 1'b1);
        base = push_cnt;
        bus_write(16'h9100, 16'h2222, 1'b0);
        chk("R9 deselected write no push", 32'(push_cnt - base), 0);
        chk("R9 word unchanged", word, 32'h9000_1111);

        // R8 overflow: dropped write, sticky flag, later writes work
        full = 1'b1;
        base = push_cnt;
        bus_write(16'hA000, 16'h3333, 1'b1);
        chk("R8 full drops push", 32'(push_cnt - base), 0);
        chk("R8 overflow set", 32'(ovf), 1);
        chk("R8 word kept", word, 32'h9000_1111);
        full = 1'b0;
        bus_write(16'hA001, 16'h4444, 1'b1);
        chk("R8 push after full clears", 32'(push_cnt - base), 1);
        chk("R8 word after recovery", last_word, 32'hA001_4444);
        chk("R8 overflow sticky", 32'(ovf), 1);

        summary();
    end
endmodule